// File: doc/BRIEF.md
# Address-Encoded Store Message Injector

This block turns single host store transactions into outgoing network messages. Software writes a message of one to eight 64-bit quad words into a memory-mapped send window. The address of that store carries the control information. The page index selects the sending context. Lower address bits give the message length and a small tag. The payload words carry only data. The block keeps no descriptor, doorbell or per-message context. Each transaction is gathered, checked and either turned into exactly one packet or discarded as a whole.

The host bus presents each store as a burst of 32-bit beats, marked with first and last flags. A message must arrive as one uninterrupted burst of exactly the beat count that its address announces. Otherwise the block raises a fragmentation fault and sends nothing. Contexts that are not enabled raise an authorization fault. A packet leaves only against a network credit. While the block waits for a credit, it holds off further host stores. A programmable watchdog ends that wait by dropping the message, which frees the host and records a sticky error together with the offending context.

Top module: `pio_msg_injector`

## Requirements
- R1: On the first beat of a store, the address is decoded as follows. Bits [5:3] hold the length in quad words minus one. Bits [11:6] hold the 6-bit tag. Bits [15:12] hold the 4-bit context index. Each quad word is two 32-bit beats, so a store must carry 2, 4, ... or 16 beats.
- R2: A complete store from an enabled context yields one packet. The first packet word is a header with the context in [31:24], the tag in [23:16], zero in [15:8] and the quad-word count in [7:0]. The payload beats then follow in arrival order. `pkt_sop` is high on the header and `pkt_eop` on the last word, and `pkt_valid` stays high on every cycle in between.
- R3: When the context's bit in `ctx_enable` is low, the store is discarded to its last beat. `auth_err` pulses for one cycle, no packet is sent and no credit is used. The two fault pulses are never high together.
- R4: When `wr_last` arrives before the announced beat count, `split_err` pulses and nothing is sent.
- R5: When the announced beat count is reached without `wr_last`, `split_err` pulses. The remaining beats, up to `wr_last`, are discarded and nothing is sent.
- R6: When a beat marked first arrives inside an unfinished store, `split_err` pulses. The interrupted store and the intruding one are both discarded.
- R7: A beat without `wr_first` while no store is open pulses `split_err`. Beats are then discarded up to `wr_last`.
- R8: Each packet consumes one credit. `credit_inc` adds one. Without a credit, no packet starts.
- R9: While a complete message waits for a credit, `wr_ready` is low. When no credit comes for `wdog_limit`+1 cycles, the message is dropped, `wr_ready` returns high, and `wdog_err` is set with `wdog_ctx` holding the context. `wdog_err` stays set until `err_clr`.
- R10: Messages leave in the order their stores completed. No store beat is accepted while a packet is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Store beat present |
| wr_ready | output | 1 | Block accepts a store beat |
| wr_first | input | 1 | Beat opens a store |
| wr_last | input | 1 | Beat closes a store |
| wr_addr | input | 16 | Store address, decoded on the first beat |
| wr_data | input | 32 | Store data beat |
| ctx_enable | input | 16 | Send permission, one bit per context |
| wdog_limit | input | 16 | Credit wait bound in cycles, minus one |
| credit_inc | input | 1 | One network credit returned |
| err_clr | input | 1 | Clears the sticky watchdog error |
| pkt_valid | output | 1 | Packet word present |
| pkt_sop | output | 1 | Header word |
| pkt_eop | output | 1 | Final packet word |
| pkt_data | output | 32 | Packet word |
| split_err | output | 1 | Fragmented-store pulse |
| auth_err | output | 1 | Unauthorized-context pulse |
| wdog_err | output | 1 | Sticky watchdog expiry |
| wdog_ctx | output | 4 | Context of the last expired message |

## Verification
A wrong beat counter or a lost first-beat latch would show at the ports within one packet. The header count or tag would be wrong, or a spurious `split_err` pulse would appear in the cycle after the faulty beat. A credit counter that drifts shows up as a packet that starts without a credit, or as a message that stalls into a watchdog expiry. The expiry is visible as a `wr_ready` low time that differs from `wdog_limit`+1 cycles. A state machine that leaves its waiting state early lets a store beat through while a packet is in flight, or reorders back-to-back messages.

// File: rtl/pmi_pkg.sv
package pmi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COLLECT = 3'd1,
    ST_DROP    = 3'd2,
    ST_WAIT    = 3'd3,
    ST_SEND    = 3'd4
  } pmi_state_e;

  function automatic logic [31:0] make_header(input logic [7:0] ctx,
                                              input logic [7:0] tag,
                                              input logic [7:0] qw_count);
    return {ctx, tag, 8'h00, qw_count};
  endfunction

endpackage

// File: rtl/pmi_addr_decode.sv
module pmi_addr_decode #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 12,
  parameter int LEN_LSB   = 3,
  parameter int LEN_W     = 3,
  parameter int TAG_W     = 6,
  localparam int CTX_W    = ADDR_W - PAGE_BITS,
  localparam int NCTX     = 1 << CTX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCTX-1:0]   ctx_enable,
  output logic [LEN_W-1:0]  qw_m1,
  output logic [TAG_W-1:0]  tag,
  output logic [CTX_W-1:0]  ctx,
  output logic              allowed
);

  localparam int TAG_LSB = LEN_LSB + LEN_W;

  logic unused_low;
  assign unused_low = ^addr[LEN_LSB-1:0];

  assign qw_m1   = addr[LEN_LSB +: LEN_W];
  assign tag     = addr[TAG_LSB +: TAG_W];
  assign ctx     = addr[PAGE_BITS +: CTX_W];
  assign allowed = ctx_enable[ctx];

endmodule

// File: rtl/pmi_payload_buf.sv
module pmi_payload_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (slot_we) slot[i] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];

endmodule

// File: rtl/pmi_credit_wdog.sv
module pmi_credit_wdog #(
  parameter int CRED_W = 4,
  parameter int WDOG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              credit_inc,
  input  logic              waiting,
  input  logic [WDOG_W-1:0] wdog_limit,
  output logic              have_credit,
  output logic              take,
  output logic              expire
);

  localparam logic [CRED_W-1:0] CRED_MAX = '1;

  logic [CRED_W-1:0] cred_q, cred_n;
  logic [WDOG_W-1:0] wd_q, wd_n;

  assign have_credit = (cred_q != '0);
  assign take        = waiting && have_credit;
  assign expire      = waiting && !have_credit && (wd_q == wdog_limit);

  always_comb begin
    cred_n = cred_q;
    if (credit_inc && !take) begin
      if (cred_q != CRED_MAX) cred_n = cred_q + CRED_W'(1);
    end else if (take && !credit_inc) begin
      cred_n = cred_q - CRED_W'(1);
    end
  end

  always_comb begin
    wd_n = wd_q;
    if (!waiting) wd_n = '0;
    else if (!have_credit && !expire) wd_n = wd_q + WDOG_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cred_q <= '0;
      wd_q   <= '0;
    end else begin
      cred_q <= cred_n;
      wd_q   <= wd_n;
    end
  end

  // R8: a credit is only taken when one is held
  p_take_needs_credit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cred_q != '0));

  // R9: the counter never runs past the programmed bound while waiting
  p_wd_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !have_credit && $stable(wdog_limit)) |-> (wd_q <= wdog_limit));

endmodule

// File: rtl/pio_msg_injector.sv
module pio_msg_injector #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 12,
  parameter int LEN_W     = 3,
  parameter int TAG_W     = 6,
  parameter int DATA_W    = 32,
  parameter int CRED_W    = 4,
  parameter int WDOG_W    = 16,
  localparam int CTX_W    = ADDR_W - PAGE_BITS,
  localparam int NCTX     = 1 << CTX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_first,
  input  logic              wr_last,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NCTX-1:0]   ctx_enable,
  input  logic [WDOG_W-1:0] wdog_limit,
  input  logic              credit_inc,
  input  logic              err_clr,
  output logic              pkt_valid,
  output logic              pkt_sop,
  output logic              pkt_eop,
  output logic [DATA_W-1:0] pkt_data,
  output logic              split_err,
  output logic              auth_err,
  output logic              wdog_err,
  output logic [CTX_W-1:0]  wdog_ctx
);
  import pmi_pkg::*;

  localparam int WPQ    = 64 / DATA_W;
  localparam int MAX_QW = 1 << LEN_W;
  localparam int DEPTH  = MAX_QW * WPQ;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int BEAT_W = $clog2(DEPTH + 1);

  pmi_state_e        state_q, state_n;
  logic [BEAT_W-1:0] cnt_q, cnt_n;
  logic [BEAT_W-1:0] oidx_q, oidx_n;
  logic [CTX_W-1:0]  ctx_q, ctx_n;
  logic [TAG_W-1:0]  tag_q, tag_n;
  logic [LEN_W-1:0]  qwm1_q, qwm1_n;
  logic              split_q, split_n;
  logic              auth_q, auth_n;
  logic              wderr_q, wderr_n;
  logic [CTX_W-1:0]  wdctx_q, wdctx_n;

  logic [LEN_W-1:0]  dec_qwm1;
  logic [TAG_W-1:0]  dec_tag;
  logic [CTX_W-1:0]  dec_ctx;
  logic              dec_allowed;

  logic              beat;
  logic              buf_we;
  logic [IDX_W-1:0]  buf_widx;
  logic [IDX_W-1:0]  buf_ridx;
  logic [DATA_W-1:0] buf_rdata;
  logic              waiting, have_credit, take, expire;
  logic [BEAT_W-1:0] dec_beats, held_beats, cnt_inc;

  pmi_addr_decode #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LEN_LSB(3),
    .LEN_W(LEN_W), .TAG_W(TAG_W)
  ) u_dec (
    .addr(wr_addr), .ctx_enable(ctx_enable),
    .qw_m1(dec_qwm1), .tag(dec_tag), .ctx(dec_ctx), .allowed(dec_allowed)
  );

  pmi_payload_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .wr_en(buf_we), .wr_idx(buf_widx), .wr_data(wr_data),
    .rd_idx(buf_ridx), .rd_data(buf_rdata)
  );

  pmi_credit_wdog #(.CRED_W(CRED_W), .WDOG_W(WDOG_W)) u_cred (
    .clk(clk), .rst_n(rst_n), .credit_inc(credit_inc), .waiting(waiting),
    .wdog_limit(wdog_limit), .have_credit(have_credit), .take(take),
    .expire(expire)
  );

  assign wr_ready   = (state_q == ST_IDLE) || (state_q == ST_COLLECT) ||
                      (state_q == ST_DROP);
  assign beat       = wr_valid && wr_ready;
  assign waiting    = (state_q == ST_WAIT);
  assign dec_beats  = (BEAT_W'(dec_qwm1) + BEAT_W'(1)) * BEAT_W'(WPQ);
  assign held_beats = (BEAT_W'(qwm1_q) + BEAT_W'(1)) * BEAT_W'(WPQ);
  assign cnt_inc    = cnt_q + BEAT_W'(1);
  assign buf_ridx   = IDX_W'(oidx_q - BEAT_W'(1));

  // next-state logic
  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    oidx_n   = oidx_q;
    ctx_n    = ctx_q;
    tag_n    = tag_q;
    qwm1_n   = qwm1_q;
    split_n  = 1'b0;
    auth_n   = 1'b0;
    wderr_n  = wderr_q;
    wdctx_n  = wdctx_q;
    buf_we   = 1'b0;
    buf_widx = '0;

    if (err_clr) wderr_n = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (beat) begin
          if (!wr_first) begin
            split_n = 1'b1;
            if (!wr_last) state_n = ST_DROP;
          end else if (!dec_allowed) begin
            auth_n = 1'b1;
            if (!wr_last) state_n = ST_DROP;
          end else begin
            buf_we = 1'b1;
            ctx_n  = dec_ctx;
            tag_n  = dec_tag;
            qwm1_n = dec_qwm1;
            cnt_n  = BEAT_W'(1);
            if (wr_last) begin
              if (dec_beats == BEAT_W'(1)) state_n = ST_WAIT;
              else split_n = 1'b1;
            end else if (dec_beats == BEAT_W'(1)) begin
              split_n = 1'b1;
              state_n = ST_DROP;
            end else begin
              state_n = ST_COLLECT;
            end
          end
        end
      end
      ST_COLLECT: begin
        if (beat) begin
          if (wr_first) begin
            split_n = 1'b1;
            state_n = wr_last ? ST_IDLE : ST_DROP;
          end else begin
            buf_we   = 1'b1;
            buf_widx = IDX_W'(cnt_q);
            cnt_n    = cnt_inc;
            if (wr_last) begin
              if (cnt_inc == held_beats) state_n = ST_WAIT;
              else begin
                split_n = 1'b1;
                state_n = ST_IDLE;
              end
            end else if (cnt_inc == held_beats) begin
              split_n = 1'b1;
              state_n = ST_DROP;
            end
          end
        end
      end
      ST_DROP: begin
        if (beat && wr_last) state_n = ST_IDLE;
      end
      ST_WAIT: begin
        if (take) begin
          oidx_n  = '0;
          state_n = ST_SEND;
        end else if (expire) begin
          wderr_n = 1'b1;
          wdctx_n = ctx_q;
          state_n = ST_IDLE;
        end
      end
      ST_SEND: begin
        oidx_n = oidx_q + BEAT_W'(1);
        if (oidx_q == held_beats) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oidx_q  <= '0;
      ctx_q   <= '0;
      tag_q   <= '0;
      qwm1_q  <= '0;
      split_q <= 1'b0;
      auth_q  <= 1'b0;
      wderr_q <= 1'b0;
      wdctx_q <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      oidx_q  <= oidx_n;
      ctx_q   <= ctx_n;
      tag_q   <= tag_n;
      qwm1_q  <= qwm1_n;
      split_q <= split_n;
      auth_q  <= auth_n;
      wderr_q <= wderr_n;
      wdctx_q <= wdctx_n;
    end
  end

  always_comb begin
    pkt_valid = (state_q == ST_SEND);
    pkt_sop   = pkt_valid && (oidx_q == '0);
    pkt_eop   = pkt_valid && (oidx_q == held_beats);
    if (oidx_q == '0)
      pkt_data = make_header(8'(ctx_q), 8'(tag_q), 8'(qwm1_q) + 8'd1);
    else
      pkt_data = buf_rdata;
  end

  assign split_err = split_q;
  assign auth_err  = auth_q;
  assign wdog_err  = wderr_q;
  assign wdog_ctx  = wdctx_q;

  // R10: the host side is closed while a packet is on the wire
  p_no_accept_in_send_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !wr_ready);

  // R2: every packet starts with its header word
  p_header_leads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid) |-> pkt_sop);

  // R2: once started, a packet is contiguous until its last word
  p_contiguous_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_eop) |=> pkt_valid);

  // R3: fault pulses are mutually exclusive
  p_faults_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({split_err, auth_err}));

  // R4: a fragmented store never coincides with packet output
  p_split_no_pkt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    split_err |-> !pkt_valid);

  // R9: the watchdog error is held until cleared
  p_wdog_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_err && !err_clr) |=> wdog_err);

endmodule

// File: tb/sim_pio_msg_injector.sv
module sim_pio_msg_injector;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, wr_ready, wr_first, wr_last;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic [15:0] ctx_enable;
  logic [15:0] wdog_limit;
  logic        credit_inc, err_clr;
  logic        pkt_valid, pkt_sop, pkt_eop;
  logic [31:0] pkt_data;
  logic        split_err, auth_err, wdog_err;
  logic [3:0]  wdog_ctx;

  int checks = 0;
  int errors = 0;

  logic [31:0] cap [0:255];
  logic        capsop [0:255];
  int ncap = 0;
  int nsplit = 0;
  int nauth = 0;

  always #4 clk = ~clk;

  pio_msg_injector u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_first(wr_first), .wr_last(wr_last), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctx_enable(ctx_enable), .wdog_limit(wdog_limit),
    .credit_inc(credit_inc), .err_clr(err_clr), .pkt_valid(pkt_valid),
    .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .pkt_data(pkt_data),
    .split_err(split_err), .auth_err(auth_err), .wdog_err(wdog_err),
    .wdog_ctx(wdog_ctx)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (pkt_valid && ncap < 256) begin
        cap[ncap]    = pkt_data;
        capsop[ncap] = pkt_sop;
        ncap++;
      end
      if (split_err) nsplit++;
      if (auth_err) nauth++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_addr(input int ctx, input int tag, input int qw);
    return {4'(ctx), 6'(tag), 3'(qw - 1), 3'b000};
  endfunction

  function automatic logic [31:0] mk_word(input int k, input int i);
    return 32'hC000_0000 + 32'(k * 256 + i);
  endfunction

  function automatic logic [31:0] mk_hdr(input int ctx, input int tag, input int qw);
    return {8'(ctx), 8'(tag), 8'h00, 8'(qw)};
  endfunction

  task automatic drive_beat(input logic f, input logic l, input logic [15:0] a,
                            input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_first = f; wr_last = l; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic bus_idle();
    @(negedge clk);
    wr_valid = 1'b0; wr_first = 1'b0; wr_last = 1'b0;
  endtask

  task automatic send_store(input int ctx, input int tag, input int qw,
                            input int nbeats, input int k);
    for (int i = 0; i < nbeats; i++)
      drive_beat(i == 0, i == nbeats - 1, mk_addr(ctx, tag, qw), mk_word(k, i));
    bus_idle();
  endtask

  task automatic give_credit(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); credit_inc = 1'b1;
      @(negedge clk); credit_inc = 1'b0;
    end
  endtask

  task automatic expect_pkt(input string req, input int base, input int ctx,
                            input int tag, input int qw, input int k);
    chk({req, " header"}, cap[base], mk_hdr(ctx, tag, qw));
    chk({req, " sop"}, 32'(capsop[base]), 32'd1);
    for (int i = 0; i < 2 * qw; i++)
      chk({req, " payload"}, cap[base + 1 + i], mk_word(k, i));
  endtask

  task automatic t_reset();
    chk("R9 reset ready", 32'(wr_ready), 32'd1);
    chk("R2 reset pkt_valid", 32'(pkt_valid), 32'd0);
    chk("R9 reset wdog_err", 32'(wdog_err), 32'd0);
  endtask

  // R1 R2 R8: two quad words from context 3
  task automatic t_basic();
    int b = ncap;
    give_credit(1);
    send_store(3, 5, 2, 4, 1);
    repeat (12) @(negedge clk);
    chk("R2 basic word count", 32'(ncap - b), 32'd5);
    expect_pkt("R1 R2 basic", b, 3, 5, 2, 1);
  endtask

  // R1 R2: longest message, top context and tag
  task automatic t_max();
    int b = ncap;
    give_credit(1);
    send_store(15, 63, 8, 16, 2);
    repeat (24) @(negedge clk);
    chk("R2 max word count", 32'(ncap - b), 32'd17);
    expect_pkt("R1 R2 max", b, 15, 63, 8, 2);
  endtask

  // R3: disabled context, credit available
  task automatic t_auth();
    int b = ncap;
    int a = nauth;
    int s = nsplit;
    give_credit(1);
    send_store(2, 7, 2, 4, 3);
    repeat (10) @(negedge clk);
    chk("R3 auth pulse", 32'(nauth - a), 32'd1);
    chk("R3 no split", 32'(nsplit - s), 32'd0);
    chk("R3 nothing sent", 32'(ncap - b), 32'd0);
    // the unused credit must still serve the next message
    send_store(4, 9, 1, 2, 4);
    repeat (10) @(negedge clk);
    chk("R3 credit kept", 32'(ncap - b), 32'd3);
    expect_pkt("R3 follow-up", b, 4, 9, 1, 4);
  endtask

  // R4: length says 3 quad words, only 4 beats arrive
  task automatic t_short();
    int b = ncap;
    int s = nsplit;
    give_credit(1);
    send_store(3, 1, 3, 4, 5);
    repeat (10) @(negedge clk);
    chk("R4 split pulse", 32'(nsplit - s), 32'd1);
    chk("R4 nothing sent", 32'(ncap - b), 32'd0);
  endtask

  // R5: length says 1 quad word, 4 beats arrive
  task automatic t_long();
    int b = ncap;
    int s = nsplit;
    send_store(3, 2, 1, 4, 6);
    repeat (10) @(negedge clk);
    chk("R5 split pulse", 32'(nsplit - s), 32'd1);
    chk("R5 nothing sent", 32'(ncap - b), 32'd0);
    chk("R5 ready after drop", 32'(wr_ready), 32'd1);
  endtask

  // R6: a new store opens inside an unfinished one
  task automatic t_interrupt();
    int b = ncap;
    int s = nsplit;
    drive_beat(1'b1, 1'b0, mk_addr(3, 4, 2), mk_word(7, 0));
    drive_beat(1'b0, 1'b0, mk_addr(3, 4, 2), mk_word(7, 1));
    drive_beat(1'b1, 1'b0, mk_addr(3, 4, 1), mk_word(8, 0));
    drive_beat(1'b0, 1'b1, mk_addr(3, 4, 1), mk_word(8, 1));
    bus_idle();
    repeat (10) @(negedge clk);
    chk("R6 split pulse", 32'(nsplit - s), 32'd1);
    chk("R6 nothing sent", 32'(ncap - b), 32'd0);
  endtask

  // R7: stray beats with no opening beat
  task automatic t_stray();
    int b = ncap;
    int s = nsplit;
    drive_beat(1'b0, 1'b0, mk_addr(3, 4, 1), mk_word(9, 0));
    drive_beat(1'b0, 1'b1, mk_addr(3, 4, 1), mk_word(9, 1));
    bus_idle();
    repeat (6) @(negedge clk);
    chk("R7 split pulse", 32'(nsplit - s), 32'd1);
    chk("R7 nothing sent", 32'(ncap - b), 32'd0);
    // the credit given in t_short still serves a clean message
    send_store(6, 11, 1, 2, 10);
    repeat (10) @(negedge clk);
    expect_pkt("R7 recovery", b, 6, 11, 1, 10);
  endtask

  // R8 R9: message waits for a credit that arrives late
  task automatic t_late_credit();
    int b = ncap;
    wdog_limit = 16'd40;
    send_store(7, 12, 1, 2, 11);
    repeat (5) @(negedge clk);
    chk("R8 no packet without credit", 32'(ncap - b), 32'd0);
    chk("R9 ready low while waiting", 32'(wr_ready), 32'd0);
    give_credit(1);
    repeat (8) @(negedge clk);
    chk("R8 packet after credit", 32'(ncap - b), 32'd3);
    expect_pkt("R8 late", b, 7, 12, 1, 11);
    chk("R9 no expiry", 32'(wdog_err), 32'd0);
  endtask

  // R9: watchdog expiry, stall length, sticky error and clear
  task automatic t_wdog();
    int b = ncap;
    int low = 0;
    wdog_limit = 16'd6;
    for (int i = 0; i < 2; i++)
      drive_beat(i == 0, i == 1, mk_addr(5, 3, 1), mk_word(12, i));
    @(negedge clk);
    wr_valid = 1'b0; wr_first = 1'b0; wr_last = 1'b0;
    while (!wr_ready && low < 100) begin
      low++;
      @(negedge clk);
    end
    chk("R9 stall cycles", 32'(low), 32'd7);
    chk("R9 error set", 32'(wdog_err), 32'd1);
    chk("R9 error context", 32'(wdog_ctx), 32'd5);
    chk("R9 dropped", 32'(ncap - b), 32'd0);
    repeat (3) @(negedge clk);
    chk("R9 sticky", 32'(wdog_err), 32'd1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R9 cleared", 32'(wdog_err), 32'd0);
  endtask

  // R10: back-to-back messages keep store order
  task automatic t_order();
    int b = ncap;
    wdog_limit = 16'd40;
    give_credit(3);
    send_store(1, 20, 1, 2, 13);
    send_store(1, 21, 2, 4, 14);
    send_store(1, 22, 1, 2, 15);
    repeat (15) @(negedge clk);
    chk("R10 word count", 32'(ncap - b), 32'd11);
    expect_pkt("R10 first", b, 1, 20, 1, 13);
    expect_pkt("R10 second", b + 3, 1, 21, 2, 14);
    expect_pkt("R10 third", b + 8, 1, 22, 1, 15);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_valid = 1'b0; wr_first = 1'b0; wr_last = 1'b0;
    wr_addr = '0; wr_data = '0;
    ctx_enable = 16'hFFFB;
    wdog_limit = 16'd40;
    credit_inc = 1'b0; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_max();
    t_auth();
    t_short();
    t_long();
    t_interrupt();
    t_stray();
    t_late_credit();
    t_wdog();
    t_order();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule